// File: doc/BRIEF.md
# Host bridge control register file

This block is the 32-bit control register file that sits beside a PCI host bridge. A bus agent reaches it through a single-cycle port: a write is taken on the clock edge while `wr_en` is high, and a read returns the addressed word combinationally on `rdata` in the same cycle. Only the low 16 address bits are decoded, so the register map repeats every 64 KiB of the port's address space.

The map holds three address-translation control words, eight interrupt map entries for PCI slots, sixteen interrupt map entries for on-board sources, twelve PCI control words and one reset control/status register. Interrupt map entries keep a fixed routing pattern in their low 31 bits and expose only an enable bit. The enable bits are sent out in parallel to an interrupt router. Writing a soft-reset bit in the reset register makes the block emit a one-cycle system reset request. The block also counts bridge resets (`warm_rst`). That count decides whether a reset is reported as a power-on reset. A separate `cold_rst` starts everything from zero. Any address outside the implemented windows, including DMA error, diagnostic, memory-control and translation-flush space, reads as zero and takes no write.

Top module: `hbr_regfile`

## Requirements
- R1: Only address bits 15:0 are decoded. Any offset outside the implemented windows (for example 0x0030–0x004f, 0xf000–0xf01f, 0x0210) reads as 0, and a write there changes no register.
- R2: Three read/write translation words sit at offsets 0x200, 0x204 and 0x208, selected by address bits 3:2. The flush range 0x20c–0x3ff reads 0 and stores nothing.
- R3: The eight PCI slot map entries occupy 0xc00–0xc3f, one per 8-byte pair, selected by address bits 5:3. The entry is the word with address bit 2 set. The word with bit 2 clear reads 0 and ignores writes.
- R4: In a map entry, only bit 31 (enable) takes a write. Bits 30:0 always read (0x1f << 6) | (i << 2) for entry i.
- R5: The sixteen on-board map entries occupy 0x1000–0x107f, selected by address bits 7:3. They follow the rules of R3 and R4. Offset 0x1080 reads 0.
- R6: Twelve fully read/write PCI control words occupy 0x2000–0x202f, selected by address bits 5:2.
- R7: The reset register is the word at 0xf024. The word at 0xf020 reads 0. A written value is first masked to bits 31:27. A 1 clears bit 31 (power-on), bit 28 and bit 27. Bits 30 (soft power-on) and 29 (soft interrupt-reset) take the written value. Bits 26:0 read 0.
- R8: A reset-register write with bit 30 set clears the reset counter and raises `sys_rst_req` for exactly the one cycle after the write edge. A write with only bit 29 set raises the pulse and keeps the counter. A write with neither bit set raises no pulse.
- R9: `warm_rst` clears every PCI slot enable. On-board enables, translation words and PCI control words keep their values.
- R10: On `warm_rst`, if the reset counter is zero, the reset register becomes 0x80000000. Otherwise it is unchanged. The counter then increments and saturates at its maximum, so it never wraps back to zero.
- R11: `cold_rst` clears the counter, the reset register, every enable, every stored word and the request pulse.
- R12: `pci_map_en[i]` and `obd_map_en[i]` equal bit 31 of the matching map entry at all times.
- R13: Priority is `cold_rst` over `warm_rst` over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high power-up reset |
| warm_rst | input | 1 | Synchronous active-high bridge reset, counted |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| addr | input | ADDR_W (32) | Byte address; bits 15:0 decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, same cycle |
| sys_rst_req | output | 1 | One-cycle system reset request |
| pci_map_en | output | 8 | PCI slot interrupt enables |
| obd_map_en | output | 16 | On-board interrupt enables |

## Verification
The hardest state to reach is a `warm_rst` that arrives while the reset counter is non-zero after a soft reset. This case tells apart the soft-power-on path, which reports power-on, from the soft-interrupt-reset path, which does not. The bench reaches it by first writing bit 30 and resetting, which gives power-on status. It then writes bit 29 and resets again, and checks that the register still holds its written soft bits. A further run of twenty bridge resets drives the counter to its saturation point. A later reset then shows no wrap back to a power-on report.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int DATA_W  = 32;
    localparam int XLAT_N  = 3;
    localparam int PMAP_N  = 8;
    localparam int OMAP_N  = 16;
    localparam int PCTL_N  = 12;

    localparam logic [31:0] RST_WMASK   = 32'hf800_0000;
    localparam logic [31:0] RST_POR_VAL = 32'h8000_0000;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_XLAT,
        RG_PMAP,
        RG_OMAP,
        RG_PCTL,
        RG_RST
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [4:0] idx;
        logic       hi;
    } dec_t;

    function automatic dec_t hbr_decode(input logic [15:0] a);
        dec_t d;
        d.rg  = RG_NONE;
        d.idx = '0;
        d.hi  = a[2];
        if (a >= 16'h0200 && a <= 16'h020b) begin
            d.rg  = RG_XLAT;
            d.idx = {3'b000, a[3:2]};
        end else if (a >= 16'h0c00 && a <= 16'h0c3f) begin
            d.rg  = RG_PMAP;
            d.idx = {2'b00, a[5:3]};
        end else if (a >= 16'h1000 && a <= 16'h107f) begin
            d.rg  = RG_OMAP;
            d.idx = a[7:3];
        end else if (a >= 16'h2000 && a <= 16'h202f) begin
            d.rg  = RG_PCTL;
            d.idx = {1'b0, a[5:2]};
        end else if (a >= 16'hf020 && a <= 16'hf027) begin
            d.rg  = RG_RST;
        end
        return d;
    endfunction

    // Fixed routing pattern held in bits 30:0 of map entry i.
    function automatic logic [30:0] hbr_map_low(input logic [4:0] i);
        return 31'h0000_07c0 | {24'b0, i, 2'b00};
    endfunction

endpackage

// File: rtl/hbr_wordbank.sv
module hbr_wordbank #(
    parameter int N  = 4,
    parameter int W  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          cold_rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_word
);

    logic [W-1:0] words_q [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (cold_rst) begin
                words_q[g] <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                words_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_idx == IW'(k)) rd_word = words_q[k];
        end
    end

endmodule

// File: rtl/hbr_intmap.sv
module hbr_intmap
    import hbr_pkg::*;
#(
    parameter int N           = 8,
    parameter bit CLR_ON_WARM = 1'b1,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          cold_rst,
    input  logic          warm_rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_bit,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_word,
    output logic [N-1:0]  en
);

    logic [N-1:0] en_q;

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (cold_rst) begin
                en_q[g] <= 1'b0;
            end else if (warm_rst) begin
                if (CLR_ON_WARM) en_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                en_q[g] <= wr_bit;
            end
        end
    end

    always_comb begin
        rd_word = {en_q[rd_idx], hbr_map_low(5'(rd_idx))};
    end

    assign en = en_q;

endmodule

// File: rtl/hbr_rstctl.sv
module hbr_rstctl
    import hbr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic        clk,
    input  logic        cold_rst,
    input  logic        warm_rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_top,
    output logic [31:0] rst_word,
    output logic        req
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [4:0]       top_q;
    logic             req_q;
    logic [4:0]       top_nx;

    // wr_top carries written bits 31:27 after masking.
    always_comb begin
        top_nx[4] = top_q[4] & ~wr_top[4];
        top_nx[3] = wr_top[3];
        top_nx[2] = wr_top[2];
        top_nx[1] = top_q[1] & ~wr_top[1];
        top_nx[0] = top_q[0] & ~wr_top[0];
    end

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            cnt_q <= '0;
            top_q <= '0;
            req_q <= 1'b0;
        end else if (warm_rst) begin
            req_q <= 1'b0;
            if (cnt_q == '0) top_q <= RST_POR_VAL[31:27];
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else if (wr_en) begin
            top_q <= top_nx;
            req_q <= wr_top[3] | wr_top[2];
            if (wr_top[3]) cnt_q <= '0;
        end else begin
            req_q <= 1'b0;
        end
    end

    assign rst_word = {top_q, 27'b0};
    assign req      = req_q;

endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
    import hbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                cold_rst,
    input  logic                warm_rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                sys_rst_req,
    output logic [PMAP_N-1:0]   pci_map_en,
    output logic [OMAP_N-1:0]   obd_map_en
);

    localparam int XLAT_IW = $clog2(XLAT_N);
    localparam int PMAP_IW = $clog2(PMAP_N);
    localparam int OMAP_IW = $clog2(OMAP_N);
    localparam int PCTL_IW = $clog2(PCTL_N);

    dec_t        dec;
    logic        unused_hi;
    logic [31:0] xlat_rd, pmap_rd, omap_rd, pctl_rd, rst_rd;
    logic        wr_xlat, wr_pmap, wr_omap, wr_pctl, wr_rst;
    logic [31:0] wmasked;

    assign dec       = hbr_decode(addr[15:0]);
    assign unused_hi = ^addr[ADDR_W-1:16];
    assign wmasked   = wdata & RST_WMASK;

    assign wr_xlat = wr_en && dec.rg == RG_XLAT;
    assign wr_pmap = wr_en && dec.rg == RG_PMAP && dec.hi;
    assign wr_omap = wr_en && dec.rg == RG_OMAP && dec.hi;
    assign wr_pctl = wr_en && dec.rg == RG_PCTL;
    assign wr_rst  = wr_en && dec.rg == RG_RST  && dec.hi;

    hbr_wordbank #(.N(XLAT_N), .W(DATA_W)) u_xlat (
        .clk(clk), .cold_rst(cold_rst), .wr_en(wr_xlat && !warm_rst),
        .wr_idx(dec.idx[XLAT_IW-1:0]), .wdata(wdata),
        .rd_idx(dec.idx[XLAT_IW-1:0]), .rd_word(xlat_rd)
    );

    hbr_wordbank #(.N(PCTL_N), .W(DATA_W)) u_pctl (
        .clk(clk), .cold_rst(cold_rst), .wr_en(wr_pctl && !warm_rst),
        .wr_idx(dec.idx[PCTL_IW-1:0]), .wdata(wdata),
        .rd_idx(dec.idx[PCTL_IW-1:0]), .rd_word(pctl_rd)
    );

    hbr_intmap #(.N(PMAP_N), .CLR_ON_WARM(1'b1)) u_pmap (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .wr_en(wr_pmap), .wr_idx(dec.idx[PMAP_IW-1:0]), .wr_bit(wdata[31]),
        .rd_idx(dec.idx[PMAP_IW-1:0]), .rd_word(pmap_rd), .en(pci_map_en)
    );

    hbr_intmap #(.N(OMAP_N), .CLR_ON_WARM(1'b0)) u_omap (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .wr_en(wr_omap), .wr_idx(dec.idx[OMAP_IW-1:0]), .wr_bit(wdata[31]),
        .rd_idx(dec.idx[OMAP_IW-1:0]), .rd_word(omap_rd), .en(obd_map_en)
    );

    hbr_rstctl #(.CNT_W(CNT_W)) u_rst (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .wr_en(wr_rst), .wr_top(wmasked[31:27]),
        .rst_word(rst_rd), .req(sys_rst_req)
    );

    always_comb begin
        unique case (dec.rg)
            RG_XLAT: rdata = xlat_rd;
            RG_PMAP: rdata = dec.hi ? pmap_rd : '0;
            RG_OMAP: rdata = dec.hi ? omap_rd : '0;
            RG_PCTL: rdata = pctl_rd;
            RG_RST:  rdata = dec.hi ? rst_rd : '0;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/hbr_regfile_chk.sv
module hbr_regfile_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              cold_rst,
    input logic              warm_rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              sys_rst_req,
    input logic [7:0]        pci_map_en,
    input logic [15:0]       obd_map_en
);

    logic at_rst_hi;
    assign at_rst_hi = addr[15:0] >= 16'hf024 && addr[15:0] <= 16'hf027;

    p_req_source_r8: assert property (@(posedge clk) disable iff (cold_rst)
        sys_rst_req |-> $past(wr_en && !warm_rst && at_rst_hi && (wdata[30] || wdata[29])));

    p_warm_pmap_r9: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> pci_map_en == 8'h00);

    p_warm_obd_r9: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> $stable(obd_map_en));

    p_hole_zero_r1: assert property (@(posedge clk) disable iff (cold_rst)
        (addr[15:0] >= 16'h0030 && addr[15:0] <= 16'h004f) |-> rdata == 32'h0);

    p_rst_low_zero_r7: assert property (@(posedge clk) disable iff (cold_rst)
        at_rst_hi |-> rdata[26:0] == 27'h0);

    p_map_lowword_r3: assert property (@(posedge clk) disable iff (cold_rst)
        (addr[15:0] >= 16'h0c00 && addr[15:0] <= 16'h0c3f && !addr[2]) |-> rdata == 32'h0);

    p_map_en_export_r12: assert property (@(posedge clk) disable iff (cold_rst)
        (addr[15:0] >= 16'h0c00 && addr[15:0] <= 16'h0c3f && addr[2])
            |-> rdata[31] == pci_map_en[addr[5:3]]);

endmodule

bind hbr_regfile hbr_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req),
    .pci_map_en(pci_map_en), .obd_map_en(obd_map_en)
);

// File: tb/hbr_regfile_bench.sv
`timescale 1ns/100ps
module hbr_regfile_bench;

    logic        clk = 1'b0;
    logic        cold_rst, warm_rst, wr_en;
    logic [31:0] addr, wdata, rdata;
    logic        sys_rst_req;
    logic [7:0]  pci_map_en;
    logic [15:0] obd_map_en;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    hbr_regfile u_hbr_regfile (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req),
        .pci_map_en(pci_map_en), .obd_map_en(obd_map_en)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] a;
        logic [31:0] d;
        logic        req;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_0c04, 32'h0000_07c0, 1'b0, 8'd4},  // R4 entry 0
        '{1'b0, 32'h0000_0c3c, 32'h0000_07dc, 1'b0, 8'd4},  // R4 entry 7
        '{1'b0, 32'h0000_0c00, 32'h0000_0000, 1'b0, 8'd3},  // R3 lower word
        '{1'b1, 32'h0000_0c0c, 32'h8000_1234, 1'b0, 8'd4},  // R4 enable write
        '{1'b0, 32'h0000_0c0c, 32'h8000_07c4, 1'b0, 8'd4},  // R4
        '{1'b1, 32'h0000_0c08, 32'hffff_ffff, 1'b0, 8'd3},  // R3 lower write
        '{1'b0, 32'h0000_0c08, 32'h0000_0000, 1'b0, 8'd3},  // R3
        '{1'b0, 32'h0000_0c0c, 32'h8000_07c4, 1'b0, 8'd3},  // R3 unchanged
        '{1'b1, 32'h0000_0204, 32'ha5a5_0001, 1'b0, 8'd2},  // R2
        '{1'b0, 32'h0000_0204, 32'ha5a5_0001, 1'b0, 8'd2},  // R2
        '{1'b1, 32'h0000_0210, 32'hffff_ffff, 1'b0, 8'd2},  // R2 flush
        '{1'b0, 32'h0000_0210, 32'h0000_0000, 1'b0, 8'd2},  // R2
        '{1'b0, 32'h0000_0200, 32'h0000_0000, 1'b0, 8'd2},  // R2 word 0 untouched
        '{1'b0, 32'h0003_0204, 32'ha5a5_0001, 1'b0, 8'd1},  // R1 alias
        '{1'b1, 32'h0000_202c, 32'h1357_9bdf, 1'b0, 8'd6},  // R6 word 11
        '{1'b0, 32'h0000_202c, 32'h1357_9bdf, 1'b0, 8'd6},  // R6
        '{1'b0, 32'h0000_2000, 32'h0000_0000, 1'b0, 8'd6},  // R6
        '{1'b1, 32'h0000_0030, 32'hdead_beef, 1'b0, 8'd1},  // R1 hole
        '{1'b0, 32'h0000_0030, 32'h0000_0000, 1'b0, 8'd1},  // R1
        '{1'b1, 32'h0000_f000, 32'hffff_ffff, 1'b0, 8'd1},  // R1
        '{1'b0, 32'h0000_f000, 32'h0000_0000, 1'b0, 8'd1},  // R1
        '{1'b1, 32'h0000_1004, 32'h8000_0000, 1'b0, 8'd5},  // R5
        '{1'b0, 32'h0000_1004, 32'h8000_07c0, 1'b0, 8'd5},  // R5
        '{1'b0, 32'h0000_107c, 32'h0000_07fc, 1'b0, 8'd5},  // R5 entry 15
        '{1'b0, 32'h0000_1080, 32'h0000_0000, 1'b0, 8'd5},  // R5
        '{1'b0, 32'h0000_f020, 32'h0000_0000, 1'b0, 8'd7},  // R7 lower word
        '{1'b1, 32'h0000_f024, 32'h8000_0000, 1'b0, 8'd7},  // R7 clear bit 31
        '{1'b0, 32'h0000_f024, 32'h0000_0000, 1'b0, 8'd7},  // R7
        '{1'b1, 32'h0000_f024, 32'h07ff_ffff, 1'b0, 8'd8},  // R8 no soft bit
        '{1'b0, 32'h0000_f024, 32'h0000_0000, 1'b0, 8'd7}   // R7 masked
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input string rq, input logic [31:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(rq, rdata, exp);
    endtask

    task automatic pulse_warm();
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cold_rst = 1'b1; warm_rst = 1'b0; wr_en = 1'b0;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;

        // R11 state after cold reset
        do_rd("R11", 32'h0000_f024, 32'h0);
        check("R11", {23'b0, sys_rst_req, pci_map_en}, 32'h0);
        check("R11", {16'b0, obd_map_en}, 32'h0);

        // R10 first bridge reset reports power-on
        pulse_warm();
        do_rd("R10", 32'h0000_f024, 32'h8000_0000);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].tag);
            if (VEC[i].wr) begin
                do_wr(VEC[i].a, VEC[i].d);
                check(rq, {31'b0, sys_rst_req}, {31'b0, VEC[i].req});
            end else begin
                do_rd(rq, VEC[i].a, VEC[i].d);
            end
        end

        // R12 exported enables
        check("R12", {24'b0, pci_map_en}, 32'h0000_0002);
        check("R12", {16'b0, obd_map_en}, 32'h0000_0001);

        // R8 soft power-on: one-cycle pulse
        do_wr(32'h0000_f024, 32'h4000_0000);
        check("R8", {31'b0, sys_rst_req}, 32'h1);
        @(negedge clk);
        check("R8", {31'b0, sys_rst_req}, 32'h0);
        do_rd("R7", 32'h0000_f024, 32'h4000_0000);

        // R9 / R10 bridge reset after counter was cleared
        pulse_warm();
        do_rd("R10", 32'h0000_f024, 32'h8000_0000);
        check("R9", {24'b0, pci_map_en}, 32'h0);
        check("R9", {16'b0, obd_map_en}, 32'h0000_0001);
        do_rd("R9", 32'h0000_0204, 32'ha5a5_0001);
        do_rd("R9", 32'h0000_202c, 32'h1357_9bdf);

        // R8 soft interrupt-reset keeps the counter
        do_wr(32'h0000_f024, 32'h2000_0000);
        check("R8", {31'b0, sys_rst_req}, 32'h1);
        do_rd("R7", 32'h0000_f024, 32'ha000_0000);
        pulse_warm();
        do_rd("R10", 32'h0000_f024, 32'ha000_0000);

        // R13 bridge reset beats a write in the same cycle
        @(negedge clk);
        addr = 32'h0000_0c04; wdata = 32'h8000_0000; wr_en = 1'b1; warm_rst = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; warm_rst = 1'b0;
        check("R13", {24'b0, pci_map_en}, 32'h0);

        // R10 counter saturates and never wraps to a power-on report
        for (int i = 0; i < 20; i++) pulse_warm();
        do_wr(32'h0000_f024, 32'h8000_0000);
        do_rd("R7", 32'h0000_f024, 32'h0);
        pulse_warm();
        do_rd("R10", 32'h0000_f024, 32'h0);

        // R11 cold reset clears stored state
        do_wr(32'h0000_1004, 32'h8000_0000);
        @(negedge clk);
        cold_rst = 1'b1;
        @(negedge clk);
        cold_rst = 1'b0;
        check("R11", {16'b0, obd_map_en}, 32'h0);
        do_rd("R11", 32'h0000_0204, 32'h0);
        pulse_warm();
        do_rd("R11", 32'h0000_f024, 32'h8000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule